// File: doc/BRIEF.md
# Priority Interrupt Controller with Acknowledge

This block collects interrupts from a set of external request pins and a few internal message sources and presents one request line to a single processor. Each source has a word-wide configuration register that holds its vector, a priority, an input polarity, an edge-or-level sense selector and a mask bit. It also has a read-only activity flag. Software reads an acknowledge register to take the most urgent pending vector, which moves that source into service. It writes an end-of-interrupt register when the handler is done.

Delivery only happens when a global enable bit in the mode register is set. Delivery is filtered by a current-task priority and by the priority of whatever is already in service. Edge-sensitive sources latch an event even while masked, so an edge captured before software unmasks a source can arrive later as a genuine vector. When nothing qualifies, an acknowledge returns a programmable spurious vector. Software learns the source count from a feature register and can loop acknowledge/end-of-interrupt pairs that many times to drain stale state.

Top module: `pic_ack`

The register map uses word addresses:

| Address | Register |
|---|---|
| 0 | Mode register; bit 0 enables delivery |
| 1 | Feature register (read-only); source count |
| 2 | Current task priority |
| 3 | Spurious vector |
| 4 | Message enable; bit k gates message k |
| 5 | Acknowledge (read) |
| 6 | End-of-interrupt (write) |
| 32 + i | Configuration of source i |

The configuration word has the following fields:

| Bits | Field |
|---|---|
| 31 | Mask |
| 30 | Activity (read-only) |
| 23 | Sense (1 = level) |
| 22 | Polarity (1 = active-high / rising) |
| 19:16 | Priority |
| 7:0 | Vector |

All other bits of the configuration word read as zero. Sources 0 to 3 are the external pins, and sources 4 to 7 are message sources 0 to 3.

## Requirements
- R1: After reset, irq_out is low and the mode bit is 0. Task priority is 0 and the spurious vector is 0xFF. Every source configuration reads 0x8040_0000, which means masked, rising-edge, priority 0 and vector 0.
- R2: Writable fields read back the last value written, and reserved bits read as zero. The end-of-interrupt register always reads 0. The feature register (address 1) reads the source count, 8.
- R3: A read of address 5 returns the vector of the deliverable source with the highest priority. Equal priorities go to the lowest source index. If no source is deliverable, the read returns the spurious vector.
- R4: irq_out is high only when all of the following hold: the mode bit is 1, and some unmasked, pending, not-in-service source has a priority greater than both the task priority and every in-service priority. A source with priority 0 never requests. A message source also needs its enable bit set.
- R5: An acknowledge that returns a real vector moves that source from pending to in service. irq_out then falls unless a strictly higher-priority source is waiting.
- R6: A write to address 6 retires the in-service source with the highest priority (lowest index on a tie). This can let a waiting source request again.
- R7: A rising edge on an edge-sense source is latched whether or not the source is masked. It stays pending until acknowledged, and clearing the mask later delivers it.
- R8: A level-sense source is pending exactly while its polarity-adjusted input is active; it is not latched. Polarity 0 means active low.
- R9: The activity bit of a source reads 1 while the source is pending or in service.
- R10: A message source latches a one-cycle pulse on msg_post[k]. It requests only while bit k of the message enable register is set; writing 0xF enables all four.
- R11: bus_rdata is loaded on the clock edge that samples bus_rd and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid after the read edge |
| ext_irq | input | 4 | External interrupt inputs |
| msg_post | input | 4 | Message interrupt pulses |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A wrong pending, in-service or mask bit shows up as irq_out disagreeing with the expected request in the same cycle. The request is a direct function of stored state and the live level inputs. A wrong selection or a stale latch shows up on the next acknowledge read, as a wrong vector or a spurious one where a real one was due. Because of this, the reference model is compared against irq_out on every cycle and against every read value.

// File: rtl/pic_ack.sv
`timescale 1ns/1ps
module pic_ack #(
  parameter int N_EXT = 4,
  parameter int N_MSG = 4,
  parameter int VW    = 8,
  parameter int PW    = 4,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic [N_MSG-1:0] msg_post,
  output logic          irq_out
);
  localparam int NSRC = N_EXT + N_MSG;
  localparam int IW   = $clog2(NSRC);
  localparam logic [AW-1:0] A_MODE = AW'(0), A_FEAT = AW'(1), A_TPRI = AW'(2),
    A_SPUR = AW'(3), A_MEN = AW'(4), A_ACK = AW'(5), A_EOI = AW'(6),
    A_SRC = AW'(32), A_SEND = AW'(32 + NSRC);

  logic             mode_q;
  logic [PW-1:0]    tpri_q;
  logic [VW-1:0]    spur_q;
  logic [N_MSG-1:0] men_q;
  logic [VW-1:0]    vec_q [NSRC];
  logic [PW-1:0]    pri_q [NSRC];
  logic [NSRC-1:0]  pol_q, sen_q, msk_q, lat_q, ins_q;
  logic [NSRC-1:0]  pend, elig, setv, take_oh, eoi_oh;
  logic [N_EXT-1:0] adj, prev_q;
  logic             best_ok, ins_ok, deliver, take, src_hit;
  logic [IW-1:0]    best_idx, ins_idx, sidx;
  logic [PW-1:0]    best_pri, ins_pri;
  logic [31:0]      rd_val;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign adj = ~(ext_irq ^ pol_q[N_EXT-1:0]);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i < N_EXT) begin : g_ext
      assign pend[i] = sen_q[i] ? adj[i] : lat_q[i];
      assign setv[i] = ~sen_q[i] & adj[i] & ~prev_q[i];
      assign elig[i] = pend[i] & ~msk_q[i] & ~ins_q[i] & (|pri_q[i]);
    end else begin : g_msg
      assign pend[i] = lat_q[i];
      assign setv[i] = msg_post[i-N_EXT];
      assign elig[i] = pend[i] & ~msk_q[i] & ~ins_q[i] & (|pri_q[i]) & men_q[i-N_EXT];
    end
  end

  always_comb begin
    best_ok = 1'b0; best_idx = '0; best_pri = '0;
    ins_ok  = 1'b0; ins_idx  = '0; ins_pri  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!best_ok || pri_q[i] > best_pri)) begin
        best_ok = 1'b1; best_idx = IW'(i); best_pri = pri_q[i];
      end
      if (ins_q[i] && (!ins_ok || pri_q[i] > ins_pri)) begin
        ins_ok = 1'b1; ins_idx = IW'(i); ins_pri = pri_q[i];
      end
    end
  end

  assign deliver = mode_q && best_ok && (best_pri > tpri_q) && (!ins_ok || best_pri > ins_pri);
  assign irq_out = deliver;
  assign take    = bus_rd && (bus_addr == A_ACK) && deliver;
  assign take_oh = take ? (NSRC'(1) << best_idx) : '0;
  assign eoi_oh  = (bus_wr && bus_addr == A_EOI && ins_ok) ? (NSRC'(1) << ins_idx) : '0;
  assign src_hit = (bus_addr >= A_SRC) && (bus_addr < A_SEND);
  assign sidx    = IW'(bus_addr - A_SRC);

  always_comb begin
    rd_val = '0;
    if (src_hit) begin
      rd_val[VW-1:0]  = vec_q[sidx];
      rd_val[16 +: PW] = pri_q[sidx];
      rd_val[22] = pol_q[sidx];
      rd_val[23] = sen_q[sidx];
      rd_val[30] = pend[sidx] | ins_q[sidx];
      rd_val[31] = msk_q[sidx];
    end else begin
      case (bus_addr)
        A_MODE:  rd_val = 32'(mode_q);
        A_FEAT:  rd_val = 32'(NSRC);
        A_TPRI:  rd_val = 32'(tpri_q);
        A_SPUR:  rd_val = 32'(spur_q);
        A_MEN:   rd_val = 32'(men_q);
        A_ACK:   rd_val = deliver ? 32'(vec_q[best_idx]) : 32'(spur_q);
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0; tpri_q <= '0; spur_q <= '1; men_q <= '0;
      pol_q <= '1; sen_q <= '0; msk_q <= '1; lat_q <= '0; ins_q <= '0;
      prev_q <= '0; bus_rdata <= '0;
      for (int i = 0; i < NSRC; i++) begin
        vec_q[i] <= '0; pri_q[i] <= '0;
      end
    end else begin
      if (bus_rd) bus_rdata <= rd_val;
      lat_q  <= (lat_q & ~take_oh) | setv;
      ins_q  <= (ins_q | take_oh) & ~eoi_oh;
      prev_q <= adj;
      if (bus_wr) begin
        if (src_hit) begin
          vec_q[sidx] <= bus_wdata[VW-1:0];
          pri_q[sidx] <= bus_wdata[16 +: PW];
          pol_q[sidx] <= bus_wdata[22];
          sen_q[sidx] <= bus_wdata[23];
          msk_q[sidx] <= bus_wdata[31];
        end
        case (bus_addr)
          A_MODE: mode_q <= bus_wdata[0];
          A_TPRI: tpri_q <= bus_wdata[PW-1:0];
          A_SPUR: spur_q <= bus_wdata[VW-1:0];
          A_MEN:  men_q  <= bus_wdata[N_MSG-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pic_ack_chk.sv
`timescale 1ns/1ps
module pic_ack_chk #(
  parameter int NSRC = 8,
  parameter int VW   = 8,
  parameter int PW   = 4,
  parameter int AW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [AW-1:0]   bus_addr,
  input logic [31:0]     bus_rdata,
  input logic            irq_out,
  input logic            mode_q,
  input logic [PW-1:0]   tpri_q,
  input logic [VW-1:0]   spur_q,
  input logic [NSRC-1:0] msk_q,
  input logic [NSRC-1:0] ins_q
);
  localparam logic [AW-1:0] A_ACK = AW'(5), A_EOI = AW'(6);

  AST_QUIET_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> !irq_out); // R4
  AST_QUIET_AT_TOP_TASK: assert property (@(posedge clk) disable iff (!rst_n)
    (tpri_q == {PW{1'b1}}) |-> !irq_out); // R4
  AST_QUIET_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (&msk_q) |-> !irq_out); // R7
  AST_SPURIOUS_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_ACK && !irq_out) |=> bus_rdata == 32'($past(spur_q))); // R3
  AST_ACK_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == A_ACK && irq_out) |=> $countones(ins_q) == $countones($past(ins_q)) + 1); // R5
  AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_addr == A_EOI && |ins_q) |=> $countones(ins_q) + 1 == $countones($past(ins_q))); // R6
  AST_EOI_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_EOI) |=> bus_rdata == 32'd0); // R2
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R11
endmodule

bind pic_ack pic_ack_chk #(.NSRC(N_EXT + N_MSG), .VW(VW), .PW(PW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .irq_out(irq_out), .mode_q(mode_q), .tpri_q(tpri_q),
  .spur_q(spur_q), .msk_q(msk_q), .ins_q(ins_q));

// File: tb/test_pic_ack.sv
`timescale 1ns/1ps
module test_pic_ack;
  localparam int NE = 4, NM = 4, NS = 8;
  logic clk = 0, rst_n = 0, wr = 0, rd = 0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0] ext = '0, msg = '0;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pic_ack i_pic_ack (.clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .ext_irq(ext), .msg_post(msg), .irq_out(irq));

  function automatic void check(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  // behavioural reference model
  int m_vec[NS], m_pri[NS];
  bit m_pol[NS], m_sen[NS], m_msk[NS], m_lat[NS], m_ins[NS], m_prev[NE];
  int m_mode, m_tpri, m_spur, m_men;
  logic [31:0] m_rd;
  bit m_rdv;

  function automatic bit m_pend(int i);
    if (i < NE && m_sen[i]) return m_pol[i] ? ext[i] : !ext[i];
    return m_lat[i];
  endfunction
  function automatic int m_best();
    int b = -1;
    for (int i = 0; i < NS; i++) begin
      bit ok = m_pend(i) && !m_msk[i] && !m_ins[i] && m_pri[i] > 0 && (i < NE || m_men[i-NE] != 0);
      if (ok && (b < 0 || m_pri[i] > m_pri[b])) b = i;
    end
    return b;
  endfunction
  function automatic int m_top();
    int t = -1;
    for (int i = 0; i < NS; i++)
      if (m_ins[i] && (t < 0 || m_pri[i] > m_pri[t])) t = i;
    return t;
  endfunction
  function automatic bit m_del();
    int b = m_best(), t = m_top();
    return m_mode != 0 && b >= 0 && m_pri[b] > m_tpri && (t < 0 || m_pri[b] > m_pri[t]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_tpri = 0; m_spur = 8'hFF; m_men = 0; m_rdv = 0;
      for (int i = 0; i < NS; i++) begin
        m_vec[i] = 0; m_pri[i] = 0; m_pol[i] = 1; m_sen[i] = 0; m_msk[i] = 1; m_lat[i] = 0; m_ins[i] = 0;
      end
      for (int i = 0; i < NE; i++) m_prev[i] = 0;
    end else begin
      automatic int b = m_best(), t = m_top(), clr = -1;
      automatic bit d = m_del();
      m_rdv = rd;
      if (rd) begin
        if (addr >= 32 && addr < 32 + NS) begin
          automatic int i = addr - 32;
          m_rd = {m_msk[i], m_pend(i) || m_ins[i], 6'b0, m_sen[i], m_pol[i], 2'b0,
                  4'(m_pri[i]), 8'b0, 8'(m_vec[i])};
        end else case (addr)
          0: m_rd = m_mode;
          1: m_rd = NS;
          2: m_rd = m_tpri;
          3: m_rd = m_spur;
          4: m_rd = m_men;
          5: if (d) begin m_rd = m_vec[b]; clr = b; end else m_rd = m_spur;
          default: m_rd = 0;
        endcase
      end
      if (clr >= 0) begin m_ins[clr] = 1; m_lat[clr] = 0; end
      for (int i = 0; i < NE; i++) begin
        automatic bit a = m_pol[i] ? ext[i] : !ext[i];
        if (!m_sen[i] && a && !m_prev[i]) m_lat[i] = 1;
        m_prev[i] = a;
      end
      for (int k = 0; k < NM; k++) if (msg[k]) m_lat[NE+k] = 1;
      if (wr) begin
        if (addr >= 32 && addr < 32 + NS) begin
          automatic int i = addr - 32;
          m_vec[i] = wdata[7:0]; m_pri[i] = wdata[19:16]; m_pol[i] = wdata[22];
          m_sen[i] = wdata[23]; m_msk[i] = wdata[31];
        end else case (addr)
          0: m_mode = wdata[0];
          2: m_tpri = wdata[3:0];
          3: m_spur = wdata[7:0];
          4: m_men = wdata[3:0];
          6: if (t >= 0) m_ins[t] = 0;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    check(32'(irq), 32'(m_del()), "R4 model irq_out");
    if (m_rdv) check(rdata, m_rd, "R2 model read data");
  end

  task automatic cyc(); @(posedge clk); #1; endtask
  task automatic bw(int a, logic [31:0] d);
    wr = 1; addr = 6'(a); wdata = d; cyc(); wr = 0;
  endtask
  task automatic br(int a, logic [31:0] exp, string tag);
    rd = 1; addr = 6'(a); cyc(); rd = 0; check(rdata, exp, tag);
  endtask
  task automatic ci(bit exp, string tag); check(32'(irq), 32'(exp), tag); endtask
  task automatic pulse(logic [3:0] p); ext = p; cyc(); ext = '0; cyc(); endtask
  function automatic logic [31:0] cfg(bit m, bit s, bit p, int pr, int v);
    return {m, 7'b0, s, p, 2'b0, 4'(pr), 8'b0, 8'(v)};
  endfunction

  initial begin
    repeat (4) cyc();
    rst_n = 1; cyc();
    ci(0, "R1 irq after reset");
    br(32, 32'h8040_0000, "R1 source reset value");
    br(3, 32'hFF, "R1 spurious reset");
    br(0, 0, "R1 mode reset");
    br(1, 8, "R2 feature count");
    bw(2, 32'hFFFF_FFF3); br(2, 3, "R2 task priority readback");
    br(6, 0, "R2 eoi reads zero");
    bw(33, 32'hFFFF_FFFF); br(33, 32'h80CF_00FF, "R2 reserved bits zero");
    bw(2, 0);
    br(5, 32'hFF, "R3 spurious when disabled");
    bw(0, 1);
    bw(32, cfg(0,0,1,5,'h10)); bw(33, cfg(0,0,1,5,'h11)); bw(34, cfg(0,0,1,7,'h12));
    pulse(4'b0011); ci(1, "R4 request");
    br(5, 'h10, "R3 tie to lowest index");
    ci(0, "R5 request drops after ack");
    br(32, 32'h4045_0010, "R9 activity in service");
    pulse(4'b0100); ci(1, "R4 preempt over in-service");
    br(5, 'h12, "R3 highest priority");
    bw(6, 0); ci(0, "R6 eoi retires highest only");
    br(34, 32'h0047_0012, "R6 retired source idle");
    bw(6, 0); ci(1, "R6 waiting source requests");
    br(5, 'h11, "R3 remaining source"); bw(6, 0); ci(0, "R6 all retired");
    bw(2, 7); pulse(4'b0100); ci(0, "R4 equal to task priority blocked");
    bw(2, 6); ci(1, "R4 above task priority");
    br(5, 'h12, "R3 after task change"); bw(6, 0); bw(2, 0);
    bw(35, cfg(1,0,1,2,'h13)); pulse(4'b1000); repeat (3) cyc();
    ci(0, "R7 masked edge no request");
    br(35, 32'hC042_0013, "R7 masked edge latched");
    bw(35, cfg(0,0,1,2,'h13)); ci(1, "R7 unmask delivers");
    br(5, 'h13, "R7 latched vector"); bw(6, 0); ci(0, "R7 done");
    ext[1] = 1; cyc(); bw(33, cfg(0,1,0,4,'h11)); cyc(); ci(0, "R8 level inactive");
    ext[1] = 0; cyc(); ci(1, "R8 level active low");
    ext[1] = 1; cyc(); ci(0, "R8 not latched");
    ext[1] = 0; cyc(); br(5, 'h11, "R8 level ack");
    ci(0, "R5 level in service");
    bw(6, 0); ci(1, "R8 level re-requests");
    ext[1] = 1; cyc(); ci(0, "R8 level released");
    bw(36, cfg(0,0,1,3,'h20)); msg = 4'b0001; cyc(); msg = 0; cyc();
    ci(0, "R10 message disabled");
    bw(4, 32'hF); ci(1, "R10 message enabled");
    br(5, 'h20, "R10 message vector"); bw(6, 0);
    bw(37, cfg(0,0,1,0,'h21)); msg = 4'b0010; cyc(); msg = 0; cyc();
    ci(0, "R4 priority zero silent");
    bw(3, 'h5A); br(5, 'h5A, "R3 programmed spurious");
    bw(0, 0); pulse(4'b0100); ci(0, "R4 mode off");
    bw(0, 1); ci(1, "R4 mode on");
    br(5, 'h12, "R3 after mode"); bw(6, 0); cyc(); cyc();
    check(rdata, 'h12, "R11 read data holds");
    cyc();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog all-R actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule